// File: doc/BRIEF.md
# Seeded Soft-Error Injector for Hash Words

This block sits in a hash data path, on either the store side or the lookup side, and can corrupt each hash word that passes through it. A corrupted word leaves the block XORed with a flip mask that has a fixed number of set bits. The row index and the lane flags that travel with the word are never changed. Words are corrupted at a rate of RATE_NUM out of RATE_DEN. The rate decision and the bit positions both come from a 128-bit pseudo-random generator inside the block. The generator is reseeded on every reset, so the same stimulus always produces the same corruption.

Words are offered with `in_valid` and are taken on a clock edge where `in_ready` is high. A word that is left clean appears after one register stage. A word that is corrupted spends one extra cycle per position draw while its mask is built, and `in_ready` stays low during that time. Consumers must wait for `out_valid` and must not assume a fixed delay.

When NOISE_EN is 0 or RATE_NUM is 0, the block is a plain one-register pass-through and is always ready. NOISE_BITS defaults to HASH_BITS/64.

Top module: `noise_injector`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` goes low, `in_ready` is high afterwards, and the generator state is loaded with 0xB504F32DB504F32D in both its upper and its lower 64-bit half.
- R2: The generator keeps two 64-bit halves `hi` and `lo`. Each step computes `a = lo ^ (lo << 23)`, `b = hi`, then the new `lo` is `b` and the new `hi` is `a ^ b ^ (a >> 17) ^ (b >> 26)`. The draw of a step is the 32-bit sum of the low 32 bits of the new `hi` and the new `lo`. The generator steps exactly once on each accepted word and once on each mask-building cycle, and at no other time.
- R3: An accepted word is corrupted exactly when (draw of its acceptance step) mod RATE_DEN < RATE_NUM.
- R4: A word that is not corrupted is presented with `out_valid` high in the cycle right after the edge that accepted it, with `out_hash` equal to the input hash.
- R5: While a corrupted word's mask is built, each cycle takes one draw, and the bit at position (draw mod HASH_BITS) is set in the mask. A position that is already set is skipped. The word is output on the edge that sets the NOISE_BITS-th distinct bit, so the output comes one cycle after acceptance for each draw taken. The output hash is the input hash XOR the mask, and exactly NOISE_BITS bits differ from the input.
- R6: `out_row` and `out_lane` always equal the row and lane flags of the accepted word.
- R7: `in_ready` is low while a mask is being built. During that time `in_valid` is ignored: the generator does not step, the pending word is not changed, and no extra output is produced.
- R8: With NOISE_EN = 0 or RATE_NUM = 0, `in_ready` is always high, and every accepted word appears bit-exact (hash, row and lanes) in the cycle after acceptance.
- R9: Every accepted word produces exactly one cycle of `out_valid`, and no other cycle has `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_row | input | ROW_W | Row index of the input word |
| in_lane | input | LANE_W | Lane flags of the input word |
| in_hash | input | HASH_BITS | Input hash word |
| out_valid | output | 1 | Output word present (one cycle) |
| out_row | output | ROW_W | Forwarded row index |
| out_lane | output | LANE_W | Forwarded lane flags |
| out_hash | output | HASH_BITS | Hash word, possibly corrupted |

## Verification
For each word, the bench computes the due cycle from its own model of the generator. A clean word must show `out_valid` in the first sample after its acceptance edge. A corrupted word must show it exactly D samples later, where D is the number of position draws the model took, including skipped duplicates. The bench drives inputs and samples outputs on the falling edge and counts falling edges from acceptance. It then compares that count with the predicted latency, so an output that comes early or late is reported as well as a wrong value. One sample after each output it checks that `out_valid` has dropped. While a mask is built, the bench keeps offering junk words, which must leave later results unchanged.

// File: rtl/noise_pkg.sv
package noise_pkg;

    localparam logic [63:0] SEED_HALF = 64'hB504_F32D_B504_F32D;

    typedef struct packed {
        logic [63:0] hi;
        logic [63:0] lo;
    } prng_state_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BUILD = 1'b1
    } inj_state_e;

    function automatic prng_state_t prng_next(prng_state_t s);
        prng_state_t r;
        logic [63:0] a;
        logic [63:0] b;
        a    = s.lo;
        b    = s.hi;
        a    = a ^ (a << 23);
        r.lo = b;
        r.hi = a ^ b ^ (a >> 17) ^ (b >> 26);
        return r;
    endfunction

    function automatic logic [31:0] prng_draw(prng_state_t s);
        return s.hi[31:0] + s.lo[31:0];
    endfunction

endpackage

// File: rtl/noise_prng.sv
module noise_prng
    import noise_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        advance,
    output logic [31:0] draw_lo
);
    prng_state_t st_q;
    prng_state_t st_nxt;

    assign st_nxt  = prng_next(st_q);
    assign draw_lo = prng_draw(st_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.hi <= SEED_HALF;
            st_q.lo <= SEED_HALF;
        end else if (advance) begin
            st_q <= st_nxt;
        end
    end
endmodule

// File: rtl/noise_rate_gate.sv
module noise_rate_gate #(
    parameter int RATE_NUM = 1,
    parameter int RATE_DEN = 100
) (
    input  logic [31:0] draw_lo,
    output logic        hit
);
    generate
        if (RATE_NUM <= 0) begin : g_never
            logic draw_unused;
            assign draw_unused = ^draw_lo;
            assign hit = 1'b0;
        end else if (RATE_NUM >= RATE_DEN) begin : g_always
            logic draw_unused;
            assign draw_unused = ^draw_lo;
            assign hit = 1'b1;
        end else begin : g_ratio
            logic [31:0] rem;
            assign rem = draw_lo % 32'(RATE_DEN);
            assign hit = rem < 32'(RATE_NUM);
        end
    endgenerate
endmodule

// File: rtl/noise_mask_builder.sv
module noise_mask_builder #(
    parameter int HASH_BITS  = 512,
    parameter int NOISE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 step,
    input  logic [31:0]          draw_lo,
    output logic [HASH_BITS-1:0] mask_nxt,
    output logic                 done
);
    localparam int CNT_W = $clog2(NOISE_BITS + 1);

    logic [HASH_BITS-1:0] mask_q;
    logic [HASH_BITS-1:0] onehot;
    logic [CNT_W-1:0]     cnt_q;
    logic [31:0]          pos;
    logic                 fresh;

    assign pos = draw_lo % 32'(HASH_BITS);

    for (genvar i = 0; i < HASH_BITS; i++) begin : g_dec
        assign onehot[i] = (pos == 32'(i));
    end

    assign fresh    = |(onehot & ~mask_q);
    assign mask_nxt = mask_q | onehot;
    assign done     = step && fresh && (cnt_q == CNT_W'(NOISE_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (step && fresh) begin
            mask_q <= mask_nxt;
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/noise_injector.sv
module noise_injector #(
    parameter int HASH_BITS  = 512,
    parameter bit NOISE_EN   = 1'b1,
    parameter int RATE_NUM   = 1,
    parameter int RATE_DEN   = 100,
    parameter int NOISE_BITS = HASH_BITS / 64,
    parameter int ROW_W      = 10,
    parameter int LANE_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ROW_W-1:0]     in_row,
    input  logic [LANE_W-1:0]    in_lane,
    input  logic [HASH_BITS-1:0] in_hash,
    output logic                 out_valid,
    output logic [ROW_W-1:0]     out_row,
    output logic [LANE_W-1:0]    out_lane,
    output logic [HASH_BITS-1:0] out_hash
);
    import noise_pkg::*;

    localparam bit ACTIVE = NOISE_EN && (RATE_NUM > 0) && (NOISE_BITS > 0);

    generate
        if (ACTIVE) begin : g_noise
            inj_state_e           st_q;
            logic [31:0]          draw_lo;
            logic                 hit;
            logic                 accept;
            logic                 building;
            logic                 build_done;
            logic [HASH_BITS-1:0] mask_nxt;
            logic [HASH_BITS-1:0] cap_hash;
            logic [ROW_W-1:0]     cap_row;
            logic [LANE_W-1:0]    cap_lane;

            assign building = (st_q == ST_BUILD);
            assign in_ready = !building;
            assign accept   = in_valid && in_ready;

            noise_prng u_prng (
                .clk     (clk),
                .rst     (rst),
                .advance (accept || building),
                .draw_lo (draw_lo)
            );

            noise_rate_gate #(
                .RATE_NUM (RATE_NUM),
                .RATE_DEN (RATE_DEN)
            ) u_gate (
                .draw_lo (draw_lo),
                .hit     (hit)
            );

            noise_mask_builder #(
                .HASH_BITS  (HASH_BITS),
                .NOISE_BITS (NOISE_BITS)
            ) u_mask (
                .clk      (clk),
                .rst      (rst),
                .clear    (accept),
                .step     (building),
                .draw_lo  (draw_lo),
                .mask_nxt (mask_nxt),
                .done     (build_done)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q      <= ST_IDLE;
                    out_valid <= 1'b0;
                    out_row   <= '0;
                    out_lane  <= '0;
                    out_hash  <= '0;
                    cap_hash  <= '0;
                    cap_row   <= '0;
                    cap_lane  <= '0;
                end else begin
                    out_valid <= 1'b0;
                    case (st_q)
                        ST_IDLE: begin
                            if (accept) begin
                                cap_hash <= in_hash;
                                cap_row  <= in_row;
                                cap_lane <= in_lane;
                                if (hit) begin
                                    st_q <= ST_BUILD;
                                end else begin
                                    out_valid <= 1'b1;
                                    out_hash  <= in_hash;
                                    out_row   <= in_row;
                                    out_lane  <= in_lane;
                                end
                            end
                        end
                        ST_BUILD: begin
                            if (build_done) begin
                                out_valid <= 1'b1;
                                out_hash  <= cap_hash ^ mask_nxt;
                                out_row   <= cap_row;
                                out_lane  <= cap_lane;
                                st_q      <= ST_IDLE;
                            end
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
            end
        end else begin : g_pass
            assign in_ready = 1'b1;

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    out_row   <= '0;
                    out_lane  <= '0;
                    out_hash  <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_hash <= in_hash;
                        out_row  <= in_row;
                        out_lane <= in_lane;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/noise_injector_chk.sv
module noise_injector_chk #(
    parameter int HASH_BITS  = 512,
    parameter bit NOISE_EN   = 1'b1,
    parameter int RATE_NUM   = 1,
    parameter int NOISE_BITS = HASH_BITS / 64,
    parameter int ROW_W      = 10,
    parameter int LANE_W     = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [ROW_W-1:0]     in_row,
    input logic [LANE_W-1:0]    in_lane,
    input logic [HASH_BITS-1:0] in_hash,
    input logic                 out_valid,
    input logic [ROW_W-1:0]     out_row,
    input logic [LANE_W-1:0]    out_lane,
    input logic [HASH_BITS-1:0] out_hash
);
    logic                 accept;
    logic                 pend_q;
    logic [HASH_BITS-1:0] ref_hash;
    logic [ROW_W-1:0]     ref_row;
    logic [LANE_W-1:0]    ref_lane;

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            ref_hash <= '0;
            ref_row  <= '0;
            ref_lane <= '0;
        end else begin
            if (accept) begin
                pend_q   <= 1'b1;
                ref_hash <= in_hash;
                ref_row  <= in_row;
                ref_lane <= in_lane;
            end else if (out_valid) begin
                pend_q <= 1'b0;
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_accept_progress_r7: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!in_ready || out_valid));

    p_fields_kept_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_row == ref_row && out_lane == ref_lane));

    p_flip_count_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_hash ^ ref_hash) == 0 ||
                       $countones(out_hash ^ ref_hash) == NOISE_BITS));

    p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> pend_q);

    generate
        if (!NOISE_EN || RATE_NUM == 0) begin : g_pass_chk
            p_pass_exact_r8: assert property (@(posedge clk) disable iff (rst)
                accept |=> (out_valid && out_hash == $past(in_hash)));
            p_always_ready_r8: assert property (@(posedge clk) disable iff (rst)
                in_ready);
        end
    endgenerate
endmodule

bind noise_injector noise_injector_chk #(
    .HASH_BITS  (HASH_BITS),
    .NOISE_EN   (NOISE_EN),
    .RATE_NUM   (RATE_NUM),
    .NOISE_BITS (NOISE_BITS),
    .ROW_W      (ROW_W),
    .LANE_W     (LANE_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_row    (in_row),
    .in_lane   (in_lane),
    .in_hash   (in_hash),
    .out_valid (out_valid),
    .out_row   (out_row),
    .out_lane  (out_lane),
    .out_hash  (out_hash)
);

// File: tb/noise_injector_tb_top.sv
`timescale 1ns/1ps
module noise_injector_tb_top;
    localparam int HB = 64;
    localparam int NB = 4;
    localparam int RN = 1;
    localparam int RD = 3;
    localparam int RW = 6;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          in_valid = 1'b0;
    logic          p_valid  = 1'b0;
    logic [RW-1:0] in_row   = '0;
    logic [LW-1:0] in_lane  = '0;
    logic [HB-1:0] in_hash  = '0;

    logic          n_ready, n_valid;
    logic [RW-1:0] n_row;
    logic [LW-1:0] n_lane;
    logic [HB-1:0] n_hash;
    logic          p_ready, p_ovalid;
    logic [RW-1:0] p_row;
    logic [LW-1:0] p_lane;
    logic [HB-1:0] p_hash;
    logic          z_ready, z_ovalid;
    logic [RW-1:0] z_row;
    logic [LW-1:0] z_lane;
    logic [HB-1:0] z_hash;

    noise_injector #(.HASH_BITS(HB), .NOISE_EN(1'b1), .RATE_NUM(RN), .RATE_DEN(RD),
                     .NOISE_BITS(NB), .ROW_W(RW), .LANE_W(LW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(n_ready),
        .in_row(in_row), .in_lane(in_lane), .in_hash(in_hash),
        .out_valid(n_valid), .out_row(n_row), .out_lane(n_lane), .out_hash(n_hash));

    noise_injector #(.HASH_BITS(HB), .NOISE_EN(1'b0), .RATE_NUM(RN), .RATE_DEN(RD),
                     .NOISE_BITS(NB), .ROW_W(RW), .LANE_W(LW)) dut_pass_i (
        .clk(clk), .rst(rst), .in_valid(p_valid), .in_ready(p_ready),
        .in_row(in_row), .in_lane(in_lane), .in_hash(in_hash),
        .out_valid(p_ovalid), .out_row(p_row), .out_lane(p_lane), .out_hash(p_hash));

    noise_injector #(.HASH_BITS(HB), .NOISE_EN(1'b1), .RATE_NUM(0), .RATE_DEN(RD),
                     .NOISE_BITS(NB), .ROW_W(RW), .LANE_W(LW)) dut_zero_i (
        .clk(clk), .rst(rst), .in_valid(p_valid), .in_ready(z_ready),
        .in_row(in_row), .in_lane(in_lane), .in_hash(in_hash),
        .out_valid(z_ovalid), .out_row(z_row), .out_lane(z_lane), .out_hash(z_hash));

    int checks = 0;
    int errors = 0;
    int hits   = 0;
    int misses = 0;
    logic [127:0] m_state;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Generator model written from the R2 definition
    function automatic logic [127:0] m_step(input logic [127:0] s);
        logic [63:0] a, b, nh;
        a  = s[63:0];
        b  = s[127:64];
        a  = a ^ (a << 23);
        nh = a ^ b ^ (a >> 17) ^ (b >> 26);
        return {nh, b};
    endfunction

    function automatic logic [31:0] m_draw(input logic [127:0] s);
        return s[95:64] + s[31:0];
    endfunction

    task automatic run_word(input logic [HB-1:0] h, input logic [RW-1:0] r,
                            input logic [LW-1:0] l);
        logic [HB-1:0] mask;
        logic [HB-1:0] exp_h;
        int lat, cnt, n;
        logic [31:0] d;
        m_state = m_step(m_state);
        d = m_draw(m_state);
        mask = '0;
        lat = 0;
        if ((d % RD) < RN) begin
            hits++;
            cnt = 0;
            while (cnt < NB) begin
                m_state = m_step(m_state);
                d = m_draw(m_state);
                lat++;
                if (!mask[d % HB]) begin
                    mask[d % HB] = 1'b1;
                    cnt++;
                end
            end
        end else begin
            misses++;
        end
        exp_h = h ^ mask;

        @(negedge clk);
        check(n_ready == 1'b1, "R7 ready when idle", 64'(n_ready), 64'd1);
        in_valid = 1'b1; p_valid = 1'b1;
        in_hash = h; in_row = r; in_lane = l;
        @(negedge clk);
        in_valid = 1'b0; p_valid = 1'b0;
        // R8: both pass-through variants one register later, bit-exact
        check(p_ovalid && p_hash == h && p_row == r && p_lane == l && p_ready,
              "R8 disabled pass-through", p_hash, h);
        check(z_ovalid && z_hash == h && z_row == r && z_lane == l && z_ready,
              "R8 zero-rate pass-through", z_hash, h);
        n = 0;
        while (!n_valid && n < 300) begin
            in_valid = 1'b1;
            in_hash = ~h; in_row = ~r; in_lane = ~l;
            @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        if (lat == 0) check(n == 0, "R4 clean latency", 64'(n), 64'd0);
        else          check(n == lat, "R5 corrupt latency", 64'(n), 64'(lat));
        check(n_hash == exp_h, lat == 0 ? "R4 clean hash" : "R5 corrupt hash", n_hash, exp_h);
        check($countones(n_hash ^ h) == (lat == 0 ? 0 : NB), "R5 flip count",
              64'($countones(n_hash ^ h)), 64'(lat == 0 ? 0 : NB));
        check(n_row == r && n_lane == l, "R6 row and lanes", {n_row, n_lane}, {r, l});
        @(negedge clk);
        check(!n_valid && !p_ovalid && !z_ovalid, "R9 single pulse",
              {n_valid, p_ovalid, z_ovalid}, 64'd0);
        check(n_ready, "R7 ready after output", 64'(n_ready), 64'd1);
    endtask

    task automatic run_batch(input int base, input int count);
        for (int i = base; i < base + count; i++) begin
            logic [HB-1:0] h;
            case (i % 5)
                0: h = '0;
                1: h = '1;
                2: h = {HB/2{2'b10}};
                3: h = 64'(i) * 64'h9E37_79B9_7F4A_7C15;
                default: h = 64'h1 << (i % HB);
            endcase
            run_word(h, RW'(i), LW'(i * 7));
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_state = {64'hB504_F32D_B504_F32D, 64'hB504_F32D_B504_F32D};
        repeat (3) @(negedge clk);
        check(!n_valid && n_ready && !p_ovalid, "R1 reset state",
              {n_valid, n_ready, p_ovalid}, 64'b010);
        rst = 1'b0;
        run_batch(0, 120);
        // R1: mid-run reset reseeds the generator
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!n_valid && n_ready, "R1 reset mid-run", {n_valid, n_ready}, 64'b01);
        rst = 1'b0;
        m_state = {64'hB504_F32D_B504_F32D, 64'hB504_F32D_B504_F32D};
        run_batch(0, 30);
        check(hits > 0 && misses > 0, "R3 both outcomes seen", 64'(hits), 64'(misses));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule